// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counting timer. A power-of-two prescaler turns the clock into counting ticks. On each tick the counter moves up by one until it equals a programmable period value. On the next tick it restarts from zero. Every such period match advances a 4-bit postscaler. When the postscaler has seen the programmed number of matches, the block raises a one-clock output pulse and the postscaler starts over. Other logic can use that pulse as a trigger, a gate or a reset.

The enable and an external reset input both pass through two-stage synchronizers before they act. A 5-bit mode field picks how the timer behaves. With bit 3 set, the timer runs once: it halts at zero after the first period match and stays halted until the enable is dropped and raised again. With bit 3 clear and any of bits 2..0 set, a high external reset holds the counter, the prescaler and the postscaler at zero. With mode zero, or in one-shot mode, the external reset has no effect. Mode bit 4 has no effect.

Top module: `period_timer`

## Requirements
- R1: While counting, `count_o` rises by one on each prescaled tick. On the tick where `count_o` equals `period_i` it returns to 0, so a period value P gives a cycle of P+1 ticks.
- R2: The prescaler produces one tick every 2^`presc_sel_i` clocks (1 to 128). A setting of 0 gives one tick per clock.
- R3: Each period match advances the postscaler. After `post_sel_i`+1 matches, `post_pulse_o` is high for the one clock that follows the clock edge of the last match. In steady state the pulses are therefore (P+1)·2^S·(N+1) clocks apart, where S is `presc_sel_i` and N is `post_sel_i`.
- R4: `on_i` and `ext_rst_i` each take effect two clocks after they change. Counting that starts from cleared state gives its first pulse at edge 2 + (P+1)·2^S·(N+1), counted from the change. With a 1:1 prescale, `count_o` reads 1 after the third edge.
- R5: While the synchronized enable is low, `count_o` holds its value and no pulse occurs.
- R6: When `mode_i` bit 3 is 1 (one-shot), the matching tick returns the counter to 0. The timer then halts and `running_o` goes low. Dropping `on_i` and raising it again restarts counting from 0.
- R7: When `mode_i` bit 3 is 0 and `mode_i[2:0]` is nonzero, a high synchronized `ext_rst_i` holds the counter, the prescaler and the postscaler at 0 and gives no pulse. This happens whatever the state of the enable.
- R8: When `mode_i` is 0, or in one-shot mode, `ext_rst_i` has no effect on counting.
- R9: After `rst_n` is asserted, `count_o` is 0, `post_pulse_o` is 0 and `running_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_i | input | 1 | Timer enable (asynchronous, synchronized inside) |
| presc_sel_i | input | 3 | Prescale select, divide by 2^value |
| post_sel_i | input | 4 | Postscale select, ratio value+1 |
| period_i | input | 8 | Period match value |
| mode_i | input | 5 | Mode field: bit 3 one-shot, bits 2..0 nonzero enable external clear |
| ext_rst_i | input | 1 | External reset input (asynchronous, synchronized inside) |
| count_o | output | 8 | Current counter value |
| post_pulse_o | output | 1 | Postscaled match pulse |
| running_o | output | 1 | High while the timer is counting |

## Verification
Each result lands at a fixed edge, counted from when the bench changes an input on a falling edge:
- The two synchronizer stages take two edges.
- The prescaler adds 2^S edges to each tick.
- The postscaled pulse appears on the edge that follows the last match.

The bench turns this into closed forms: 2 + ticks·2^S for the counter and 2 + (P+1)·2^S·(N+1) for the first pulse. It counts rising edges and samples every output on the falling edge that follows. For enable and external-reset changes it checks the exact edge count: two more edges of counting, then a frozen value, or an exact +10 while an ignored reset is high.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;

  localparam int unsigned MODE_W = 5;

  // Last prescaler count before a tick: 2^sel - 1.
  function automatic logic [7:0] presc_last(input logic [7:0] sel);
    return 8'((32'd1 << sel) - 32'd1);
  endfunction

  // One-shot operation is selected by mode bit 3.
  function automatic logic is_oneshot(input logic [MODE_W-1:0] m);
    return m[3];
  endfunction

  // External input acts as a synchronous clear in periodic modes with low bits set.
  function automatic logic ext_clears(input logic [MODE_W-1:0] m);
    return (m[3] == 1'b0) && (m[2:0] != 3'd0);
  endfunction

endpackage

// File: rtl/pt_sync.sv
module pt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler
  import period_timer_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned CW = (1 << SEL_W) - 1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] last_val;

  assign last_val = CW'(presc_last(8'(sel)));
  assign tick     = run && !clr && (pcnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (clr || !run)    pcnt <= '0;
    else if (tick)           pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

  // R2: a tick always restarts the prescale count
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));
  // R7: clear empties the prescaler
  p_presc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         match_evt
);
  assign match_evt = tick && !clr && (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clr)        count <= '0;
    else if (match_evt)  count <= '0;
    else if (tick)       count <= count + 1'b1;
  end

  // R1: a non-matching tick steps the count by one
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !match_evt && !clr) |=> (count == $past(count) + 1'b1));
  // R1: a match returns the count to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (count == '0));
  // R5: no tick, no clear means the count holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count));
  // R7: clear forces zero
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          match_evt,
  input  logic          clr,
  input  logic [PW-1:0] sel,
  output logic          pulse
);
  logic [PW-1:0] pcount;
  logic          ratio_hit;

  assign ratio_hit = match_evt && (pcount == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcount <= '0;
      pulse  <= 1'b0;
    end else if (clr) begin
      pcount <= '0;
      pulse  <= 1'b0;
    end else begin
      pulse <= ratio_hit;
      if (ratio_hit)      pcount <= '0;
      else if (match_evt) pcount <= pcount + 1'b1;
    end
  end

  // R3: every pulse follows a period match on the previous edge
  p_pulse_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(match_evt));
  // R7: clear empties the postscaler and gives no pulse
  p_post_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcount == '0 && !pulse));
endmodule

// File: rtl/period_timer.sv
module period_timer
  import period_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRESC_W     = 3,
  parameter int unsigned POST_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               on_i,
  input  logic [PRESC_W-1:0] presc_sel_i,
  input  logic [POST_W-1:0]  post_sel_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               ext_rst_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               post_pulse_o,
  output logic               running_o
);
  // Named internal events
  logic on_s, ext_s, on_d, on_rise;
  logic oneshot_mode, clr_evt, run_q, active;
  logic tick, match_evt;

  pt_sync #(.STAGES(SYNC_STAGES)) u_sync_on (
    .clk(clk), .rst_n(rst_n), .d(on_i), .q(on_s));
  pt_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .d(ext_rst_i), .q(ext_s));

  assign oneshot_mode = is_oneshot(mode_i);
  assign clr_evt      = ext_s && ext_clears(mode_i);
  assign on_rise      = on_s && !on_d;
  assign active       = on_s && (!oneshot_mode || run_q || on_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_d  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      on_d <= on_s;
      if (!on_s)                           run_q <= 1'b0;
      else if (oneshot_mode && match_evt)  run_q <= 1'b0;
      else if (on_rise)                    run_q <= 1'b1;
    end
  end

  pt_prescaler #(.SEL_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(active), .clr(clr_evt),
    .sel(presc_sel_i), .tick(tick));

  pt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_evt),
    .period(period_i), .count(count_o), .match_evt(match_evt));

  pt_postscaler #(.PW(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .clr(clr_evt),
    .sel(post_sel_i), .pulse(post_pulse_o));

  assign running_o = active;

  // R6: a one-shot match stops the timer on the next cycle
  p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_mode && match_evt && !on_rise) |=> !running_o);
  // R5: no ticks while the synchronized enable is low
  p_off_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !on_s |-> !tick);
  // R8: the external input cannot clear in mode zero or one-shot
  p_ext_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == '0) || oneshot_mode) |-> !clr_evt);
endmodule

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       on_i = 1'b0;
  logic [2:0] presc_sel_i = '0;
  logic [3:0] post_sel_i = '0;
  logic [7:0] period_i = '0;
  logic [4:0] mode_i = '0;
  logic       ext_rst_i = 1'b0;
  logic [7:0] count_o;
  logic       post_pulse_o;
  logic       running_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  period_timer dut (
    .clk(clk), .rst_n(rst_n), .on_i(on_i), .presc_sel_i(presc_sel_i),
    .post_sel_i(post_sel_i), .period_i(period_i), .mode_i(mode_i),
    .ext_rst_i(ext_rst_i), .count_o(count_o), .post_pulse_o(post_pulse_o),
    .running_o(running_o));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One rising edge, then sample on the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Clear everything with a periodic clear mode, leave mode selected
  task automatic clear_all(input logic [4:0] next_mode);
    mode_i    = 5'd1;
    ext_rst_i = 1'b1;
    repeat (4) step();
    mode_i    = next_mode;
    ext_rst_i = 1'b0;
  endtask

  // Edges until the pulse is seen high; -1 on timeout
  task automatic edges_to_pulse(input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      step();
      if (post_pulse_o) begin n = k; break; end
    end
  endtask

  initial begin
    int n, c0, pulses, t;
    // R9: reset state
    #5;
    check("R9 count in reset", count_o, 0);
    check("R9 pulse in reset", post_pulse_o, 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R9 count after reset", count_o, 0);
    check("R9 running after reset", running_o, 0);

    // R4: start from clear state, 1:1 prescale, count 1 after third edge
    period_i = 8'd200; mode_i = 5'd1;
    on_i = 1'b1;
    n = -1;
    for (int k = 1; k <= 10; k++) begin
      step();
      if (count_o == 8'd1) begin n = k; break; end
    end
    check("R4 first count edge", n, 3);

    // R1/R2: count sequence with period 4, divide by 2
    period_i = 8'd4; presc_sel_i = 3'd1; post_sel_i = 4'd0;
    clear_all(5'd1);
    for (int e = 1; e <= 30; e++) begin
      step();
      check("R1 R2 count sequence", count_o, (e < 2) ? 0 : (((e - 2) / 2) % 5));
    end

    // R3/R4: sweep prescale, postscale and period
    for (int s = 0; s < 4; s++) begin
      for (int np = 0; np < 4; np++) begin
        for (int pi = 0; pi < 3; pi++) begin
          int p;
          p = (pi == 0) ? 0 : ((pi == 1) ? 2 : 7);
          presc_sel_i = 3'(s); post_sel_i = 4'(np); period_i = 8'(p);
          clear_all(5'd1);
          t = (p + 1) * (1 << s) * (np + 1);
          edges_to_pulse(t + 10, n);
          check("R4 first pulse edge", n, 2 + t);
          edges_to_pulse(t + 10, n);
          check("R3 pulse spacing", n, t);
        end
      end
    end

    // R5: enable low freezes the count after two edges
    presc_sel_i = 3'd0; post_sel_i = 4'd0; period_i = 8'd250;
    clear_all(5'd1);
    repeat (6) step();
    c0 = count_o;
    on_i = 1'b0;
    repeat (10) step();
    check("R5 count after disable", count_o, c0 + 2);
    pulses = 0;
    c0 = count_o;
    for (int k = 0; k < 10; k++) begin step(); if (post_pulse_o) pulses++; end
    check("R5 count held", count_o, c0);
    check("R5 no pulse while off", pulses, 0);
    check("R5 running low", running_o, 0);

    // R6: one-shot run, period 3, 1:1
    period_i = 8'd3;
    clear_all(5'd8);
    repeat (2) step();
    on_i = 1'b1;
    pulses = 0;
    for (int k = 0; k < 30; k++) begin step(); if (post_pulse_o) pulses++; end
    check("R6 one pulse in one-shot", pulses, 1);
    check("R6 halted count", count_o, 0);
    check("R6 running low after halt", running_o, 0);
    on_i = 1'b0;
    repeat (4) step();
    on_i = 1'b1;
    repeat (3) step();
    check("R6 restart count", count_o, 1);

    // R8: one-shot ignores external input
    period_i = 8'd200;
    on_i = 1'b0;
    clear_all(5'd8);
    repeat (2) step();
    on_i = 1'b1;
    repeat (8) step();
    c0 = count_o;
    ext_rst_i = 1'b1;
    repeat (10) step();
    check("R8 one-shot ignores ext", count_o, c0 + 10);
    ext_rst_i = 1'b0;

    // R8: mode zero ignores external input
    period_i = 8'd250;
    clear_all(5'd0);
    repeat (5) step();
    c0 = count_o;
    ext_rst_i = 1'b1;
    repeat (10) step();
    check("R8 mode zero ignores ext", count_o, c0 + 10);
    ext_rst_i = 1'b0;

    // R7: clear mode holds zero, bit 4 set as well
    mode_i = 5'b10010;
    repeat (5) step();
    ext_rst_i = 1'b1;
    pulses = 0;
    repeat (3) step();
    for (int k = 0; k < 10; k++) begin
      step();
      if (post_pulse_o) pulses++;
      if (count_o != 0) pulses += 100;
    end
    check("R7 held at zero, no pulse", pulses, 0);
    check("R7 count zero", count_o, 0);
    ext_rst_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule